// File: doc/BRIEF.md
# Line Diagnostic Mode Decoder and All-Ones Reference Clock Selector

This block serves one port of a line interface. It collects the diagnostic test requests for that port: local loopback, remote loopback, dual loopback, transmit-all-ones and a pseudo-random test source. A control-mode input decides whether the requests come from host register bits or from hardware pins. Pin requests pass through a stability qualifier before they count. The block then decodes the chosen request set into path-select enables for the loopback datapaths and the pattern generator. The loopback datapaths and the pattern generator themselves sit outside this block.

While all-ones transmission is active, the block replaces the positive and negative transmit data with an alternating-mark all-ones pattern. It also picks the reference clock for that pattern. The master clock and the transmit clock trade the primary and fallback roles according to where jitter attenuation is placed. An activity monitor on each clock makes the selector move to the fallback clock when the primary clock stops toggling. The select output is registered, so an external clock multiplexer sees one clean transition.

Top module: `diag_mode_sel`

## Requirements
- R1: In host mode (`ctrl_pin_mode`=0), a change on the host request inputs appears on the enable outputs one system-clock cycle later.
- R2: A dual-loopback request drives both `lloop_en` and `rloop_en` high.
- R3: `aones_en` is high only when all-ones is requested and neither remote nor dual loopback is requested. All-ones may be active together with local loopback.
- R4: `prbs_en` is always low in pin mode, whatever `host_prbs` is. In host mode it follows `host_prbs`.
- R5: A pin request takes effect only after it has held one level for `QUAL_CYCLES` consecutive system-clock cycles. A pulse shorter than that has no effect on any enable.
- R6: While `aones_en` is high, the transmit data inputs are ignored. Exactly one of `tx_pos_out`/`tx_neg_out` is high, and the high one swaps every cycle. While `aones_en` is low, the outputs equal the inputs.
- R7: `ja_place` encodes 2'b00 none, 2'b01 transmit side, 2'b10 receive side, 2'b11 none. The primary clock is the transmit clock (`ref_sel`=1) for 2'b10 and the master clock (`ref_sel`=0) otherwise.
- R8: A clock is lost after it shows no edge for `loss_limit` system-clock cycles. If the primary clock is lost and the fallback clock is alive, `ref_sel` moves to the fallback. It returns to the primary once the primary toggles again.
- R9: During and right after reset, every enable is low, `ref_sel` is 0 and the transmit outputs equal the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_pin_mode | input | 1 | 1 = requests come from pins, 0 = from host bits |
| host_lloop | input | 1 | Host local loopback request |
| host_rloop | input | 1 | Host remote loopback request |
| host_dloop | input | 1 | Host dual loopback request |
| host_aones | input | 1 | Host all-ones request |
| host_prbs | input | 1 | Host pseudo-random source request |
| pin_req | input | 4 | Pin requests {aones, dloop, rloop, lloop} |
| ja_place | input | 2 | Jitter attenuator placement |
| loss_limit | input | LOSS_W | Edge-free cycles before a clock counts as lost |
| mclk_in | input | 1 | Master clock, observed for activity |
| tclk_in | input | 1 | Transmit clock, observed for activity |
| tx_pos_in | input | 1 | Positive transmit data in |
| tx_neg_in | input | 1 | Negative transmit data in |
| lloop_en | output | 1 | Local loopback path enable |
| rloop_en | output | 1 | Remote loopback path enable |
| aones_en | output | 1 | All-ones pattern active |
| prbs_en | output | 1 | Pseudo-random source enable |
| ref_sel | output | 1 | All-ones reference clock select, 0 master, 1 transmit |
| tx_pos_out | output | 1 | Positive transmit data out |
| tx_neg_out | output | 1 | Negative transmit data out |

## Verification
Embedded assertions check, on every cycle, that all-ones never coexists with remote loopback and that the pseudo-random source stays off after pin mode was selected. They also check that the all-ones pattern keeps exactly one rail high and alternates, that a qualified pin level only changes to a level it has held, and that the reference select follows the primary clock while that clock is alive. Some behaviours can only be shown by the bench's scenarios: a short pin pulse being rejected, the one-cycle host latency, and the switch to the fallback clock and back after a clock stops and restarts. The same holds for the transmit data passing through when all-ones is blocked by loopback.

// File: rtl/diag_pkg.sv
package diag_pkg;

    localparam int N_PIN_REQ = 4;

    typedef enum logic [1:0] {
        JA_NONE  = 2'b00,
        JA_TXSIDE = 2'b01,
        JA_RXSIDE = 2'b10,
        JA_SPARE = 2'b11
    } ja_place_e;

    typedef enum logic {
        SRC_MCLK = 1'b0,
        SRC_TCLK = 1'b1
    } clk_src_e;

    typedef struct packed {
        logic prbs;
        logic aones;
        logic dloop;
        logic rloop;
        logic lloop;
    } diag_req_t;

    typedef struct packed {
        logic prbs_en;
        logic aones_en;
        logic rloop_en;
        logic lloop_en;
    } diag_en_t;

    function automatic diag_en_t decode_req(input diag_req_t r);
        diag_en_t e;
        e.lloop_en = r.lloop | r.dloop;
        e.rloop_en = r.rloop | r.dloop;
        e.aones_en = r.aones & ~r.rloop & ~r.dloop;
        e.prbs_en  = r.prbs;
        return e;
    endfunction

    function automatic clk_src_e primary_src(input ja_place_e p);
        return (p == JA_RXSIDE) ? SRC_TCLK : SRC_MCLK;
    endfunction

endpackage

// File: rtl/pin_qualifier.sv
module pin_qualifier #(
    parameter int QUAL_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic qual_o
);
    localparam int CW = $clog2(QUAL_CYCLES + 1);
    localparam logic [CW-1:0] LIM = CW'(QUAL_CYCLES - 1);

    logic          smp;
    logic [CW-1:0] cnt;
    logic          hit;

    assign hit = (raw_i == smp) && (cnt >= LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            smp    <= 1'b0;
            cnt    <= '0;
            qual_o <= 1'b0;
        end else begin
            smp <= raw_i;
            if (raw_i != smp)
                cnt <= '0;
            else if (cnt < LIM)
                cnt <= cnt + 1'b1;
            if (hit)
                qual_o <= raw_i;
        end
    end

    // R5
    qual_held_level_chk: assert property (@(posedge clk) disable iff (rst)
        (qual_o != $past(qual_o)) |-> ($past(smp) == qual_o));

endmodule

// File: rtl/clk_act_mon.sv
module clk_act_mon #(
    parameter int LOSS_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mon_clk_i,
    input  logic [LOSS_W-1:0] limit_i,
    output logic              lost_o
);
    logic [2:0]        sy;
    logic              edge_seen;
    logic [LOSS_W-1:0] idle_cnt;

    assign edge_seen = sy[2] ^ sy[1];
    assign lost_o    = (idle_cnt >= limit_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            sy       <= '0;
            idle_cnt <= '0;
        end else begin
            sy <= {sy[1:0], mon_clk_i};
            if (edge_seen)
                idle_cnt <= '0;
            else if (idle_cnt != '1)
                idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // R8
    edge_clears_loss_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_seen && limit_i != '0 && $stable(limit_i)) |=> !lost_o);

endmodule

// File: rtl/diag_mode_sel.sv
module diag_mode_sel
    import diag_pkg::*;
#(
    parameter int QUAL_CYCLES = 3,
    parameter int LOSS_W      = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctrl_pin_mode,
    input  logic                 host_lloop,
    input  logic                 host_rloop,
    input  logic                 host_dloop,
    input  logic                 host_aones,
    input  logic                 host_prbs,
    input  logic [N_PIN_REQ-1:0] pin_req,
    input  logic [1:0]           ja_place,
    input  logic [LOSS_W-1:0]    loss_limit,
    input  logic                 mclk_in,
    input  logic                 tclk_in,
    input  logic                 tx_pos_in,
    input  logic                 tx_neg_in,
    output logic                 lloop_en,
    output logic                 rloop_en,
    output logic                 aones_en,
    output logic                 prbs_en,
    output logic                 ref_sel,
    output logic                 tx_pos_out,
    output logic                 tx_neg_out
);
    logic [N_PIN_REQ-1:0] pin_q;
    diag_req_t            host_r, pin_r, eff_r;
    diag_en_t             en_q;
    logic                 m_lost, t_lost;
    clk_src_e             prim, sel_q, sel_d;
    logic                 prim_lost, fb_lost;
    logic                 phase;

    for (genvar i = 0; i < N_PIN_REQ; i++) begin : g_qual
        pin_qualifier #(.QUAL_CYCLES(QUAL_CYCLES)) u_q (
            .clk   (clk),
            .rst   (rst),
            .raw_i (pin_req[i]),
            .qual_o(pin_q[i])
        );
    end

    assign host_r = '{prbs: host_prbs, aones: host_aones, dloop: host_dloop,
                      rloop: host_rloop, lloop: host_lloop};
    assign pin_r  = '{prbs: 1'b0, aones: pin_q[3], dloop: pin_q[2],
                      rloop: pin_q[1], lloop: pin_q[0]};
    assign eff_r  = ctrl_pin_mode ? pin_r : host_r;

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= decode_req(eff_r);
    end

    assign lloop_en = en_q.lloop_en;
    assign rloop_en = en_q.rloop_en;
    assign aones_en = en_q.aones_en;
    assign prbs_en  = en_q.prbs_en;

    clk_act_mon #(.LOSS_W(LOSS_W)) u_mmon (
        .clk(clk), .rst(rst), .mon_clk_i(mclk_in), .limit_i(loss_limit), .lost_o(m_lost)
    );
    clk_act_mon #(.LOSS_W(LOSS_W)) u_tmon (
        .clk(clk), .rst(rst), .mon_clk_i(tclk_in), .limit_i(loss_limit), .lost_o(t_lost)
    );

    always_comb begin
        prim      = primary_src(ja_place_e'(ja_place));
        prim_lost = (prim == SRC_TCLK) ? t_lost : m_lost;
        fb_lost   = (prim == SRC_TCLK) ? m_lost : t_lost;
        sel_d     = (prim_lost && !fb_lost) ? clk_src_e'(~prim) : prim;
    end

    always_ff @(posedge clk) begin
        if (rst) sel_q <= SRC_MCLK;
        else     sel_q <= sel_d;
    end
    assign ref_sel = sel_q;

    always_ff @(posedge clk) begin
        if (rst) phase <= 1'b0;
        else     phase <= ~phase;
    end

    assign tx_pos_out = aones_en ? phase  : tx_pos_in;
    assign tx_neg_out = aones_en ? ~phase : tx_neg_in;

    // R3
    aones_vs_rloop_chk: assert property (@(posedge clk) disable iff (rst)
        aones_en |-> !rloop_en);

    // R4
    prbs_pin_off_chk: assert property (@(posedge clk) disable iff (rst)
        $past(ctrl_pin_mode) |-> !prbs_en);

    // R6
    aones_one_rail_chk: assert property (@(posedge clk) disable iff (rst)
        aones_en |-> (tx_pos_out != tx_neg_out));

    // R6
    aones_alternate_chk: assert property (@(posedge clk) disable iff (rst)
        (aones_en && $past(aones_en)) |-> (tx_pos_out != $past(tx_pos_out)));

    // R7
    rx_side_tclk_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ja_place) == JA_RXSIDE && !$past(t_lost)) |-> (ref_sel == SRC_TCLK));

endmodule

// File: tb/sim_diag_mode_sel.sv
module sim_diag_mode_sel;
    localparam int QC = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctrl_pin_mode = 1'b0;
    logic host_lloop = 0, host_rloop = 0, host_dloop = 0, host_aones = 0, host_prbs = 0;
    logic [3:0] pin_req = '0;
    logic [1:0] ja_place = 2'b00;
    logic [7:0] loss_limit = 8'd20;
    logic mclk_in = 1'b0, tclk_in = 1'b0;
    logic m_run = 1'b1, t_run = 1'b1;
    logic tx_pos_in = 1'b0, tx_neg_in = 1'b0;
    logic lloop_en, rloop_en, aones_en, prbs_en, ref_sel, tx_pos_out, tx_neg_out;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;
    always #30 if (m_run) mclk_in = ~mclk_in;
    always #30 if (t_run) tclk_in = ~tclk_in;

    diag_mode_sel u0 (
        .clk(clk), .rst(rst), .ctrl_pin_mode(ctrl_pin_mode),
        .host_lloop(host_lloop), .host_rloop(host_rloop), .host_dloop(host_dloop),
        .host_aones(host_aones), .host_prbs(host_prbs), .pin_req(pin_req),
        .ja_place(ja_place), .loss_limit(loss_limit), .mclk_in(mclk_in), .tclk_in(tclk_in),
        .tx_pos_in(tx_pos_in), .tx_neg_in(tx_neg_in),
        .lloop_en(lloop_en), .rloop_en(rloop_en), .aones_en(aones_en), .prbs_en(prbs_en),
        .ref_sel(ref_sel), .tx_pos_out(tx_pos_out), .tx_neg_out(tx_neg_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] ens();
        return {4'b0, prbs_en, aones_en, rloop_en, lloop_en};
    endfunction

    task automatic set_host(input logic l, r, d, a, p);
        host_lloop = l; host_rloop = r; host_dloop = d; host_aones = a; host_prbs = p;
    endtask

    task automatic t_reset();
        rst = 1'b1; tx_pos_in = 1'b1; tx_neg_in = 1'b0;
        set_host(1, 1, 1, 1, 1);
        cyc(4);
        check("R9 enables in reset", ens(), 8'h0);
        check("R9 ref_sel in reset", {7'b0, ref_sel}, 8'h0);
        check("R9 tx pass in reset", {6'b0, tx_pos_out, tx_neg_out}, 8'h2);
        set_host(0, 0, 0, 0, 0);
        rst = 1'b0;
        cyc(1);
        check("R9 enables after reset", ens(), 8'h0);
    endtask

    task automatic t_host();
        ctrl_pin_mode = 1'b0;
        set_host(1, 0, 0, 0, 0);
        cyc(1);
        check("R1 host lloop one cycle", ens(), 8'h1);
        set_host(0, 1, 0, 0, 1);
        cyc(1);
        check("R1 host rloop+prbs R4", ens(), 8'ha);
        set_host(0, 0, 1, 0, 0);
        cyc(1);
        check("R2 dual loopback both", ens(), 8'h3);
    endtask

    task automatic t_aones();
        tx_pos_in = 1'b1; tx_neg_in = 1'b1;
        set_host(1, 0, 0, 1, 0);
        cyc(1);
        check("R3 aones with lloop", ens(), 8'h5);
        for (int i = 0; i < 4; i++) begin
            logic prev;
            prev = tx_pos_out;
            check("R6 one rail high", {7'b0, tx_pos_out ^ tx_neg_out}, 8'h1);
            cyc(1);
            check("R6 rails alternate", {7'b0, tx_pos_out}, {7'b0, ~prev});
        end
        set_host(0, 1, 0, 1, 0);
        tx_pos_in = 1'b0; tx_neg_in = 1'b1;
        cyc(1);
        check("R3 aones blocked by rloop", ens(), 8'h2);
        check("R6 pass-through when blocked", {6'b0, tx_pos_out, tx_neg_out}, 8'h1);
        set_host(0, 0, 1, 1, 0);
        cyc(1);
        check("R3 aones blocked by dloop", ens(), 8'h3);
        set_host(0, 0, 0, 0, 0);
        cyc(1);
    endtask

    task automatic t_pins();
        ctrl_pin_mode = 1'b1;
        host_prbs = 1'b1;
        cyc(QC + 4);
        check("R4 prbs off in pin mode", ens(), 8'h0);
        pin_req = 4'b0001;
        cyc(1);
        pin_req = 4'b0000;
        cyc(QC + 4);
        check("R5 short pulse ignored", ens(), 8'h0);
        pin_req = 4'b0001;
        cyc(1);
        check("R5 not yet qualified", ens(), 8'h0);
        cyc(QC + 4);
        check("R5 held pin qualified", ens(), 8'h1);
        pin_req = 4'b1000;
        cyc(QC + 4);
        check("R5 pin aones", ens(), 8'h4);
        pin_req = 4'b0000;
        host_prbs = 1'b0;
        ctrl_pin_mode = 1'b0;
        cyc(QC + 4);
    endtask

    task automatic t_clocks();
        ja_place = 2'b00;
        cyc(10);
        check("R7 none -> master", {7'b0, ref_sel}, 8'h0);
        ja_place = 2'b10;
        cyc(3);
        check("R7 rx side -> transmit", {7'b0, ref_sel}, 8'h1);
        ja_place = 2'b01;
        cyc(3);
        check("R7 tx side -> master", {7'b0, ref_sel}, 8'h0);
        m_run = 1'b0;
        cyc(45);
        check("R8 master lost -> fallback", {7'b0, ref_sel}, 8'h1);
        m_run = 1'b1;
        cyc(15);
        check("R8 master back -> primary", {7'b0, ref_sel}, 8'h0);
        ja_place = 2'b10;
        t_run = 1'b0;
        cyc(45);
        check("R8 transmit lost -> master", {7'b0, ref_sel}, 8'h0);
        m_run = 1'b0;
        cyc(45);
        check("R8 both lost -> primary", {7'b0, ref_sel}, 8'h1);
        m_run = 1'b1; t_run = 1'b1;
        cyc(15);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1..: actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_host();
        t_aones();
        t_pins();
        t_clocks();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule